// File: doc/BRIEF.md
# Lockstep Valid-Tagged Three-Stage Pipeline

This block is a three-stage datapath that moves as a single unit. Words enter through a two-entry input buffer and cross two stage registers. Each stage register carries a valid tag. Finished words land in a two-entry output buffer. Each stage applies a small combinational transform that a parameter selects: add, subtract or XOR with a constant. On every clock where the step is allowed, the whole chain moves forward at once. The head of the input buffer, if there is one, is consumed into stage 1. Stage 1 moves into stage 2. A valid stage 2 word, after the last transform, is written into the output buffer.

When the input buffer is empty, stage 1 is loaded with a bubble. Words already in flight keep moving and reach the output without any further input. The only thing that holds the pipeline is a valid word in stage 2 with nowhere to go, because the output buffer is full. In that case nothing at all changes inside the chain.

Both edges are valid/ready streams. An input word is taken on a clock where `s_valid` and `s_ready` are both high, and `s_ready` is high exactly when the input buffer has a free slot. An output word is handed over on a clock where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` holds its value.

Top module: `lockstep_pipe`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `m_valid` is 0 and `s_ready` is 1. Both stage tags are cleared.
- R2: A word accepted at clock edge k, with the pipeline otherwise empty and `m_ready` high, shows on `m_valid`/`m_data` after edge k+3 and not before.
- R3: If the input buffer is empty when the pipeline steps, stage 1 takes a bubble and the words already in flight keep advancing. With no new input, every accepted word reaches the output.
- R4: With the default parameters (8-bit data), each output equals f2(f1(f0(x))). Here f0(x) = x + 0x11, f1(x) = x XOR 0x5A and f2(x) = x + 0x03, all taken modulo 256.
- R5: A bubble in stage 2 writes nothing into the output buffer. The number of words delivered never exceeds the number accepted.
- R6: The pipeline fails to step only when stage 2 is valid and the output buffer holds two words. In every other case it steps.
- R7: A step is all or nothing. While blocked, no input word is consumed and neither stage changes. With `m_ready` held low and `s_valid` held high from empty, exactly six words are accepted (two output, two stage, two input) before `s_ready` drops.
- R8: Outputs come out in acceptance order, with no word lost or repeated, under random input gaps and random output back-pressure.
- R9: `s_ready` is 1 exactly when the input buffer holds fewer than two words. `m_valid` is 1 exactly when the output buffer is non-empty. `m_data` stays stable while `m_valid` is high and `m_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Upstream word present |
| s_ready | output | 1 | Input buffer has room |
| s_data | input | W | Upstream word |
| m_valid | output | 1 | Output buffer non-empty |
| m_ready | input | 1 | Downstream takes the word |
| m_data | output | W | Oldest finished word |

## Verification
The bench targets the case where stage 2 is valid and the output buffer is full. A design that stalls only part of the chain there would drop a word from stage 1 or consume an input word into nothing. A design that never stalls would overwrite the output buffer. Long gaps with no input check that in-flight words drain. A design that freezes on an empty input would strand them, and one that ignores the tag would emit phantom words. The single-word latency probe catches an extra or missing register, and the hold-while-not-ready test catches an output that changes under back-pressure.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_XOR = 2'd1,
    FN_SUB = 2'd2
  } fn_kind_e;
endpackage

// File: rtl/lp_fifo.sv
module lp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  output logic           full,
  output logic           empty,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign occ     = cnt;
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/lp_stage_fn.sv
module lp_stage_fn
  import lockstep_pkg::*;
#(
  parameter int          W    = 8,
  parameter fn_kind_e    KIND = FN_ADD,
  parameter int unsigned K    = 0
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] KV = W'(K);

  generate
    if (KIND == FN_ADD) begin : g_add
      assign y = x + KV;
    end else if (KIND == FN_XOR) begin : g_xor
      assign y = x ^ KV;
    end else begin : g_sub
      assign y = x - KV;
    end
  endgenerate
endmodule

// File: rtl/lp_core.sv
module lp_core
  import lockstep_pkg::*;
#(
  parameter int          W       = 8,
  parameter fn_kind_e    F0_KIND = FN_ADD,
  parameter int unsigned F0_K    = 'h11,
  parameter fn_kind_e    F1_KIND = FN_XOR,
  parameter int unsigned F1_K    = 'h5A,
  parameter fn_kind_e    F2_KIND = FN_ADD,
  parameter int unsigned F2_K    = 'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         head_valid,
  input  logic [W-1:0] head_data,
  output logic         head_take,
  input  logic         sink_full,
  output logic         sink_put,
  output logic [W-1:0] sink_data,
  output logic         tag1,
  output logic         tag2
);
  logic [W-1:0] d1, d2;
  logic [W-1:0] f0_y, f1_y;
  logic         advance;

  lp_stage_fn #(.W(W), .KIND(F0_KIND), .K(F0_K)) u_f0 (.x(head_data), .y(f0_y));
  lp_stage_fn #(.W(W), .KIND(F1_KIND), .K(F1_K)) u_f1 (.x(d1),        .y(f1_y));
  lp_stage_fn #(.W(W), .KIND(F2_KIND), .K(F2_K)) u_f2 (.x(d2),        .y(sink_data));

  // One global decision per cycle: hold everything or move everything.
  assign advance   = !(tag2 && sink_full);
  assign head_take = advance && head_valid;
  assign sink_put  = advance && tag2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1 <= 1'b0;
      tag2 <= 1'b0;
      d1   <= '0;
      d2   <= '0;
    end else if (advance) begin
      tag1 <= head_valid;
      if (head_valid) d1 <= f0_y;
      tag2 <= tag1;
      d2   <= f1_y;
    end
  end
endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe
  import lockstep_pkg::*;
#(
  parameter int          W       = 8,
  parameter int          DEPTH   = 2,
  parameter fn_kind_e    F0_KIND = FN_ADD,
  parameter int unsigned F0_K    = 'h11,
  parameter fn_kind_e    F1_KIND = FN_XOR,
  parameter int unsigned F1_K    = 'h5A,
  parameter fn_kind_e    F2_KIND = FN_ADD,
  parameter int unsigned F2_K    = 'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic         in_full, in_empty, out_full, out_empty;
  logic [CW-1:0] in_occ, out_occ;
  logic [W-1:0] head_data, sink_data;
  logic         head_take, sink_put;
  logic         tag1, tag2;

  lp_fifo #(.W(W), .DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n),
    .wr_en(s_valid), .wr_data(s_data),
    .rd_en(head_take), .rd_data(head_data),
    .full(in_full), .empty(in_empty), .occ(in_occ)
  );

  lp_core #(
    .W(W),
    .F0_KIND(F0_KIND), .F0_K(F0_K),
    .F1_KIND(F1_KIND), .F1_K(F1_K),
    .F2_KIND(F2_KIND), .F2_K(F2_K)
  ) u_core (
    .clk(clk), .rst_n(rst_n),
    .head_valid(!in_empty), .head_data(head_data), .head_take(head_take),
    .sink_full(out_full), .sink_put(sink_put), .sink_data(sink_data),
    .tag1(tag1), .tag2(tag2)
  );

  lp_fifo #(.W(W), .DEPTH(DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sink_put), .wr_data(sink_data),
    .rd_en(m_ready), .rd_data(m_data),
    .full(out_full), .empty(out_empty), .occ(out_occ)
  );

  assign s_ready = !in_full;
  assign m_valid = !out_empty;
endmodule

// File: rtl/lockstep_pipe_chk.sv
module lockstep_pipe_chk #(
  parameter int W  = 8,
  parameter int CW = 2,
  parameter int DEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [W-1:0]  m_data,
  input logic          tag1,
  input logic          tag2,
  input logic          in_empty,
  input logic          out_full,
  input logic [CW-1:0] in_occ,
  input logic [CW-1:0] out_occ,
  input logic [W-1:0]  head_data
);
  // R9: word on the output is held while the consumer is not ready
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R7: blocked step leaves both stage tags and the input buffer untouched
  a_r7_atomic_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tag2 && out_full) |=> ($stable(tag1) && tag2 && $stable(in_occ) || $past(in_occ) != in_occ && in_occ == $past(in_occ) + 1'b1));

  // R6 / R3: when not blocked, stage 2 inherits the stage 1 tag
  a_r6_steps_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag2 && out_full) |=> (tag2 == $past(tag1)));

  // R2: a present input word while free lands in stage 1
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_empty && !(tag2 && out_full)) |=> tag1);

  // R3: empty input while free yields a bubble in stage 1
  a_r3_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (in_empty && !(tag2 && out_full)) |=> !tag1);

  // R5: a bubble in stage 2 never grows the output buffer
  a_r5_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !tag2 |=> (out_occ <= $past(out_occ)));

  // R9: buffers stay within their depth
  always_comb begin
    if (rst_n) begin
      a_r9_no_overflow: assert (int'(in_occ) <= DEPTH && int'(out_occ) <= DEPTH);
    end
  end
endmodule

bind lockstep_pipe lockstep_pipe_chk #(.W(W), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .tag1(tag1), .tag2(tag2),
  .in_empty(in_empty), .out_full(out_full),
  .in_occ(in_occ), .out_occ(out_occ),
  .head_data(head_data)
);

// File: tb/sim_lockstep_pipe.sv
module sim_lockstep_pipe;
  localparam int PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         s_valid, s_ready, m_valid, m_ready;
  logic [W-1:0] s_data, m_data;

  int checks = 0;
  int fails  = 0;
  int accepted = 0;
  int delivered = 0;

  always #(PERIOD/2) clk = ~clk;

  lockstep_pipe u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  function automatic logic [W-1:0] rf0(input logic [W-1:0] x); return x + 8'h11; endfunction
  function automatic logic [W-1:0] rf1(input logic [W-1:0] x); return x ^ 8'h5A; endfunction
  function automatic logic [W-1:0] rf2(input logic [W-1:0] x); return x + 8'h03; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queues for the buffers, tagged slots for the stages.
  logic [W-1:0] q_in[$];
  logic [W-1:0] q_out[$];
  logic [W-1:0] sb[$];
  bit           v1, v2;
  logic [W-1:0] x1, x2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_in.delete(); q_out.delete(); sb.delete();
      v1 = 0; v2 = 0; x1 = '0; x2 = '0;
    end else begin
      bit in_fire, out_fire, blocked;
      logic [W-1:0] got;
      in_fire  = s_valid && (q_in.size() < 2);
      out_fire = m_ready && (q_out.size() > 0);
      blocked  = v2 && (q_out.size() == 2);
      if (out_fire) begin
        got = q_out.pop_front();
        delivered++;
        if (sb.size() == 0) check(1'b0, "R5", m_data, 0);
        else begin
          logic [W-1:0] e;
          e = sb.pop_front();
          check(m_data == e, "R8", m_data, e);
        end
      end
      if (!blocked) begin
        if (v2) q_out.push_back(rf2(x2));
        v2 = v1; x2 = rf1(x1);
        if (q_in.size() > 0) begin v1 = 1; x1 = rf0(q_in.pop_front()); end
        else v1 = 0;
      end
      if (in_fire) begin
        q_in.push_back(s_data);
        sb.push_back(rf2(rf1(rf0(s_data))));
        accepted++;
      end
    end
  end

  // Cycle-by-cycle comparison of the ports against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      check(s_ready == (q_in.size() < 2), "R9", s_ready, q_in.size() < 2);
      check(m_valid == (q_out.size() > 0), "R5", m_valid, q_out.size() > 0);
      if (m_valid && q_out.size() > 0)
        check(m_data == q_out[0], "R4", m_data, q_out[0]);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive_random(input int n, input int pin, input int pout);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = ($urandom % 100) < pin;
      s_data  = W'($urandom);
      m_ready = ($urandom % 100) < pout;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R1", m_valid, 0);
    check(s_ready == 1'b1, "R1", s_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0, "R1", m_valid, 0);
    check(s_ready == 1'b1, "R1", s_ready, 1);

    // R2: single-word latency, accepted at the next edge, visible after three more
    s_valid = 1'b1; s_data = 8'h20; m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      check(m_valid == 1'b0, "R2", m_valid, 0);
      @(negedge clk);
    end
    check(m_valid == 1'b0, "R2", m_valid, 0);
    @(negedge clk);
    check(m_valid == 1'b1, "R2", m_valid, 1);
    check(m_data == rf2(rf1(rf0(8'h20))), "R4", m_data, rf2(rf1(rf0(8'h20))));
    repeat (3) @(negedge clk);

    // R3: sparse input, words must drain through bubbles
    drive_random(300, 25, 100);
    s_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(delivered == accepted, "R3", delivered, accepted);

    // R7: global stall from empty with no consumer
    begin
      int base;
      base = accepted;
      m_ready = 1'b0; s_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        s_data = W'(8'hA0 + i);
        @(negedge clk);
      end
      check((accepted - base) == 6, "R7", accepted - base, 6);
      check(s_ready == 1'b0, "R7", s_ready, 0);
      check(m_valid == 1'b1, "R6", m_valid, 1);
      s_valid = 1'b0; m_ready = 1'b1;
      repeat (12) @(negedge clk);
      check(delivered == accepted, "R8", delivered, accepted);
    end

    // R8 / R6: random gaps and random back-pressure
    drive_random(2000, 60, 40);
    drive_random(2000, 90, 80);
    drive_random(1000, 30, 20);
    s_valid = 1'b0; m_ready = 1'b1;
    repeat (12) @(negedge clk);
    check(delivered == accepted, "R8", delivered, accepted);
    check(sb.size() == 0, "R5", sb.size(), 0);
    summary();
  end
endmodule